// File: doc/BRIEF.md
# Video Port Address Command Decoder

This block sits behind the two 16-bit write ports of a video processor: a control port and a data port. Software writes an address command to the control port. The command is either one register-set halfword, or two halfwords that together form a 32-bit access command. The block decodes the command into a target memory and a 16-bit current address. Each following data-port write goes into that memory at the current address. After each write the address advances by an increment that software sets through a register write.

Two memories live inside the block. The tile memory is addressed in bytes and written in 16-bit halfwords. The colour memory holds 64 entries of 9 bits each. Each memory has a combinational read port for the display logic. In an access command the 16-bit address is split across the two halves: the first halfword carries address bits 13:0 and the second carries address bits 15:14 in its lowest two bits. The parameter `TILE_AW` sets how many word-address bits of tile storage are actually built. Its default is 11. Setting `TILE_AW = 15` gives the full 64 KB; with fewer bits, the upper addresses alias onto the built storage.

Top module: `vid_cmd_decoder`

## Requirements
- R1: After reset there is no half-assembled command and no valid access target, `cur_addr` is 0 and the increment is 0, so an accepted data write leaves `cur_addr` unchanged.
- R2: Two non-register control writes form a command. First halfword H, then second halfword L. The address is {L[1:0], H[13:0]}, visible on `cur_addr` one cycle after L. H[15:14] = 01 selects the tile memory.
- R3: H[15:14] = 11 selects the colour memory. Entry `cur_addr[6:1]` (palette p, colour n at byte 32p+2n) stores data bits 11:9, 7:5 and 3:1. It reads back as a halfword with those bits in place and every other bit 0.
- R4: A tile data write stores the halfword at the even byte address `cur_addr & ~1`. It reads back through `tile_rd_addr`, whose bit 0 is ignored.
- R5: After each accepted data write the address grows by the increment value. Tile addresses wrap modulo 65536.
- R6: For the colour memory, only `cur_addr[6:0]` steps, modulo 128. Bits 15:7 stay unchanged.
- R7: A control write with bits 15:14 = 10 is a register write. Bits 12:8 give the register number and bits 7:0 the value; register 15 sets the increment. It completes in one halfword and discards a half-assembled command. Register writes with any other number leave the increment unchanged.
- R8: A data-port write discards a half-assembled command, so the next control write is again a first halfword.
- R9: Data writes have no effect while no valid target exists: before any command, or after a completed command with H[15:14] = 00.
- R10: When both ports are written in the same cycle, the control write is processed and the data write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control-port write strobe |
| ctrl_data | input | 16 | Control-port halfword |
| data_we | input | 1 | Data-port write strobe |
| data_in | input | 16 | Data-port halfword |
| tile_rd_addr | input | 16 | Tile memory read byte address |
| tile_rd_data | output | 16 | Tile memory read halfword |
| cram_rd_idx | input | 6 | Colour entry to read (palette*16 + colour) |
| cram_rd_data | output | 16 | Colour entry, packed in the 9-bit layout |
| cur_addr | output | 16 | Current access address |

## Verification
The bound checker enforces several rules on every cycle. It checks the address assembled from the two halves, the step by the increment after an accepted write, the colour-address wrap that leaves bits 15:7 untouched, the stable address while no target is valid or while a control write takes the cycle, and the clearing of the half-command flag by data and register writes. Other behaviour shows up only in the bench's scenarios. These include the stored memory contents and the colour bit packing. They also include the real effect of flag clearing on the next command, the effect of a register number other than 15, and wrap-around of the tile address at 0xFFFF.

// File: rtl/vid_cmd_decoder.sv
module vid_cmd_decoder #(
  parameter int TILE_AW = 11,
  parameter int INC_REG = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_we,
  input  logic [15:0] ctrl_data,
  input  logic        data_we,
  input  logic [15:0] data_in,
  input  logic [15:0] tile_rd_addr,
  output logic [15:0] tile_rd_data,
  input  logic [5:0]  cram_rd_idx,
  output logic [15:0] cram_rd_data,
  output logic [15:0] cur_addr
);
  localparam int TILE_WORDS = 1 << TILE_AW;
  localparam logic [4:0] INC_SEL = 5'(INC_REG);

  typedef enum logic [1:0] {T_NONE = 2'd0, T_TILE = 2'd1, T_CRAM = 2'd2} tgt_t;

  logic        pending;
  logic [15:0] hi_half;
  logic [15:0] addr_q;
  logic [7:0]  step_q;
  tgt_t        tgt_q;

  logic [15:0] tile_mem [TILE_WORDS];
  logic [8:0]  cram_mem [64];

  wire is_reg  = ctrl_data[15:14] == 2'b10;
  wire data_ok = data_we && !ctrl_we;
  wire do_tile = data_ok && tgt_q == T_TILE;
  wire do_cram = data_ok && tgt_q == T_CRAM;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      hi_half <= '0;
      addr_q  <= '0;
      step_q  <= '0;
      tgt_q   <= T_NONE;
    end else if (ctrl_we) begin
      if (is_reg) begin
        pending <= 1'b0;
        if (ctrl_data[12:8] == INC_SEL) step_q <= ctrl_data[7:0];
      end else if (!pending) begin
        hi_half <= ctrl_data;
        pending <= 1'b1;
      end else begin
        pending <= 1'b0;
        addr_q  <= {ctrl_data[1:0], hi_half[13:0]};
        case (hi_half[15:14])
          2'b01:   tgt_q <= T_TILE;
          2'b11:   tgt_q <= T_CRAM;
          default: tgt_q <= T_NONE;
        endcase
      end
    end else if (data_we) begin
      pending <= 1'b0;
      if (tgt_q == T_TILE) addr_q <= addr_q + {8'd0, step_q};
      else if (tgt_q == T_CRAM) addr_q <= {addr_q[15:7], addr_q[6:0] + step_q[6:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (do_tile) tile_mem[addr_q[TILE_AW:1]] <= data_in;
    if (do_cram) cram_mem[addr_q[6:1]] <= {data_in[11:9], data_in[7:5], data_in[3:1]};
  end

  logic [8:0] cram_word;
  assign cram_word    = cram_mem[cram_rd_idx];
  assign cram_rd_data = {4'd0, cram_word[8:6], 1'b0, cram_word[5:3], 1'b0, cram_word[2:0], 1'b0};
  assign tile_rd_data = tile_mem[tile_rd_addr[TILE_AW:1]];
  assign cur_addr     = addr_q;
endmodule

// File: rtl/vid_cmd_decoder_chk.sv
module vid_cmd_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctrl_we,
  input logic [15:0] ctrl_data,
  input logic        data_we,
  input logic        pending,
  input logic [15:0] hi_half,
  input logic [15:0] addr_q,
  input logic [7:0]  step_q,
  input logic [1:0]  tgt
);
  a_r2_assemble: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we && pending && ctrl_data[15:14] != 2'b10
    |=> addr_q == {$past(ctrl_data[1:0]), $past(hi_half[13:0])});

  a_r5_tile_step: assert property (@(posedge clk) disable iff (!rst_n)
    data_we && !ctrl_we && tgt == 2'd1
    |=> addr_q == $past(addr_q) + {8'd0, $past(step_q)});

  a_r6_cram_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    data_we && !ctrl_we && tgt == 2'd2
    |=> addr_q[15:7] == $past(addr_q[15:7]));

  a_r7_reg_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we && ctrl_data[15:14] == 2'b10 |=> !pending);

  a_r8_data_clears: assert property (@(posedge clk) disable iff (!rst_n)
    data_we && !ctrl_we |=> !pending);

  a_r9_no_target: assert property (@(posedge clk) disable iff (!rst_n)
    data_we && !ctrl_we && tgt == 2'd0 |=> $stable(addr_q));

  a_r10_ctrl_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we && data_we && !(pending && ctrl_data[15:14] != 2'b10) |=> $stable(addr_q));
endmodule

bind vid_cmd_decoder vid_cmd_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_data(ctrl_data),
  .data_we(data_we), .pending(pending), .hi_half(hi_half), .addr_q(addr_q),
  .step_q(step_q), .tgt(tgt_q)
);

// File: tb/vid_cmd_decoder_bench.sv
`timescale 1ns/1ps
module vid_cmd_decoder_bench;
  logic clk = 0, rst_n = 0;
  logic ctrl_we = 0, data_we = 0;
  logic [15:0] ctrl_data = 0, data_in = 0, tile_rd_addr = 0;
  logic [5:0] cram_rd_idx = 0;
  logic [15:0] tile_rd_data, cram_rd_data, cur_addr;
  int nchk = 0, nerr = 0;

  always #2 clk = ~clk;

  vid_cmd_decoder #(.TILE_AW(15)) u_vid_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_data(ctrl_data),
    .data_we(data_we), .data_in(data_in), .tile_rd_addr(tile_rd_addr),
    .tile_rd_data(tile_rd_data), .cram_rd_idx(cram_rd_idx),
    .cram_rd_data(cram_rd_data), .cur_addr(cur_addr));

  // {first half, second half, data, expected address}
  localparam logic [63:0] VEC [5] = '{
    {16'h4000, 16'h0000, 16'h1234, 16'h0000},
    {16'h4000, 16'h0001, 16'hBEEF, 16'h4000},
    {16'h7FFF, 16'h0003, 16'hA5A5, 16'hFFFF},
    {16'h5234, 16'h0002, 16'h0F0F, 16'h9234},
    {16'h6001, 16'h0000, 16'h7777, 16'h2001}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ctrl(input logic [15:0] w);
    @(negedge clk) ctrl_we = 1; ctrl_data = w;
    @(negedge clk) ctrl_we = 0;
  endtask

  task automatic dwr(input logic [15:0] w);
    @(negedge clk) data_we = 1; data_in = w;
    @(negedge clk) data_we = 0;
  endtask

  task automatic cmd(input logic [15:0] h, input logic [15:0] l);
    ctrl(h); ctrl(l);
  endtask

  task automatic tile_is(input string tag, input logic [15:0] a, input logic [15:0] exp);
    tile_rd_addr = a; #0.5; chk(tag, tile_rd_data, exp);
  endtask

  task automatic cram_is(input string tag, input logic [5:0] i, input logic [15:0] exp);
    cram_rd_idx = i; #0.5; chk(tag, cram_rd_data, exp);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    @(negedge clk); @(negedge clk) rst_n = 1;
  endtask

  initial begin
    #(4 * 100000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 reset address", cur_addr, 16'h0000);
    cmd(16'h4040, 16'h0000);
    dwr(16'hAAAA);
    chk("R1 zero increment after reset", cur_addr, 16'h0040);
    tile_is("R4 tile write at 0x0040", 16'h0040, 16'hAAAA);

    ctrl(16'h8F02);
    for (int i = 0; i < 5; i++) begin
      cmd(VEC[i][63:48], VEC[i][47:32]);
      chk("R2 assembled address", cur_addr, VEC[i][15:0]);
      dwr(VEC[i][31:16]);
      chk("R5 step by increment", cur_addr, VEC[i][15:0] + 16'd2);
      tile_is("R4 even-aligned store", VEC[i][15:0] & 16'hFFFE, VEC[i][31:16]);
    end
    tile_is("R4 odd read address", 16'h2001, 16'h7777);

    cmd(16'hC04A, 16'h0000);
    chk("R3 colour address p2 c5", cur_addr, 16'h004A);
    dwr(16'hFFFF);
    cram_is("R3 colour packing", 6'd37, 16'h0EEE);
    cmd(16'hC07E, 16'h0000);
    dwr(16'h0222);
    chk("R6 colour wrap to 0", cur_addr, 16'h0000);
    dwr(16'h0444);
    cram_is("R6 entry 63", 6'd63, 16'h0222);
    cram_is("R6 entry 0 after wrap", 6'd0, 16'h0444);
    cmd(16'hC0FE, 16'h0003);
    dwr(16'h0002);
    chk("R6 upper bits kept", cur_addr, 16'hC080);

    ctrl(16'h4000);
    ctrl(16'h8F04);
    cmd(16'h4010, 16'h0000);
    chk("R7 register write drops half command", cur_addr, 16'h0010);
    dwr(16'h0101);
    chk("R7 increment set to 4", cur_addr, 16'h0014);
    ctrl(16'h9010);
    dwr(16'h0202);
    chk("R7 other register keeps increment", cur_addr, 16'h0018);

    ctrl(16'h4020);
    dwr(16'h0303);
    cmd(16'h4100, 16'h0000);
    chk("R8 data write drops half command", cur_addr, 16'h0100);

    cmd(16'h4200, 16'h0000);
    dwr(16'h1111);
    cmd(16'h4200, 16'h0000);
    @(negedge clk) ctrl_we = 1; ctrl_data = 16'h8F08; data_we = 1; data_in = 16'h5555;
    @(negedge clk) ctrl_we = 0; data_we = 0;
    chk("R10 address held", cur_addr, 16'h0200);
    tile_is("R10 data ignored", 16'h0200, 16'h1111);
    dwr(16'h2222);
    chk("R10 control applied", cur_addr, 16'h0208);

    do_reset();
    dwr(16'hDEAD);
    chk("R9 no command address", cur_addr, 16'h0000);
    tile_is("R9 no command store", 16'h0000, 16'h1234);
    ctrl(16'h8F02);
    cmd(16'h0300, 16'h0000);
    dwr(16'hBEEF);
    chk("R9 code 00 address", cur_addr, 16'h0300);
    tile_is("R9 code 00 store", 16'h0000, 16'h1234);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule